// File: doc/BRIEF.md
# Interrupt Request Detection Unit

This block turns a set of asynchronous external interrupt pins and synchronous peripheral interrupt lines into latched request flags. Each external pin has a run-time mode that selects level or edge detection. Each peripheral line has a detection style fixed when the block is built. A per-source enable gates the request, and a per-source route bit sends it to exactly one place: the CPU or the transfer controller. Flags that latch an edge clear themselves when their destination acknowledges.

Sources are numbered with the external pins first (indices 0 to N_EXT-1) and the peripheral lines after them (N_EXT to N_EXT+N_PER-1). Among the CPU-routed candidates, a priority resolver presents a single winner with its index and priority. The configuration comes in on plain input ports, so a register file elsewhere can drive them.

Top module: `irq_detect_unit`

## Requirements
- R1: Each external pin i has a 2-bit mode at `ext_mode[2*i+:2]`: 00 = active-low level, 01 = falling edge, 10 = rising edge, 11 = both edges. A transition that the selected mode does not name sets no flag.
- R2: External pins pass through a two-flop synchronizer. An edge that the pin makes between clock edges shows on `flags` after the third following rising clock edge, and not after the second.
- R3: Peripheral line j (source N_EXT+j) is edge-detected when `PER_EDGE[j]` is 1, and level-detected (active high) when it is 0. An edge-detected line sets its flag at the first clock edge after it rises, and the flag stays set while the line stays high. A level-detected line's flag follows the line one clock later.
- R4: A level-detected flag follows its active level. An acknowledge does not clear it while the level is active, and it drops once the level goes inactive.
- R5: `src_en[i]` = 0 blocks the request of source i on both outputs. The flag itself still latches and stays visible on `flags`.
- R6: `src_to_xfer[i]` = 1 routes source i only to `xfer_req[i]`. A value of 0 routes it only to the CPU resolver. No source requests both.
- R7: A `cpu_ack` pulse with `cpu_ack_id` = i clears the edge flag of a CPU-routed source i at the next clock edge. The same pulse has no effect on a transfer-routed source.
- R8: `xfer_ack[i]` clears the edge flag of a transfer-routed source i at the next clock edge. It has no effect on a CPU-routed source.
- R9: Among enabled, flagged, CPU-routed sources, the highest 4-bit priority at `src_prio[4*i+:4]` wins, and ties go to the lower index. Priority 0 masks the source. `cpu_req` is 1 only when a winner exists, and `cpu_req_id` and `cpu_req_prio` report that winner.
- R10: If an edge for a source arrives in the same cycle as its acknowledge, the flag stays set.
- R11: After reset, every flag is 0 and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | N_EXT | Asynchronous external interrupt pins |
| ext_mode | input | 2*N_EXT | Detection mode per external pin |
| per_line | input | N_PER | Synchronous peripheral interrupt lines |
| src_en | input | N_SRC | Per-source request enable |
| src_to_xfer | input | N_SRC | Per-source route: 1 = transfer controller, 0 = CPU |
| src_prio | input | 4*N_SRC | Per-source CPU priority, 0 = masked |
| cpu_ack | input | 1 | CPU accepts the interrupt named by cpu_ack_id |
| cpu_ack_id | input | IDW | Index of the accepted source |
| xfer_ack | input | N_SRC | Per-source one-cycle transfer acknowledge |
| flags | output | N_SRC | Latched request flags |
| cpu_req | output | 1 | A CPU request is pending |
| cpu_req_id | output | IDW | Index of the winning CPU source |
| cpu_req_prio | output | 4 | Priority of the winning CPU source |
| xfer_req | output | N_SRC | Per-source transfer-controller trigger |

## Verification
The embedded properties check the following on every cycle. An edge hit always leaves the flag set in the next cycle, even when an acknowledge arrives with it. An active level always holds its flag. An acknowledge without a new edge always empties an edge flag. The CPU winner is always enabled, CPU-routed, flagged and unmasked. Only the bench scenarios can show the latencies from pin to flag, that a mode ignores the transitions it does not name, the order of priorities and ties, and that an acknowledge sent to the wrong route leaves the flag alone.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        MODE_LOW  = 2'b00,
        MODE_FALL = 2'b01,
        MODE_RISE = 2'b10,
        MODE_BOTH = 2'b11
    } det_mode_e;

    // One detection event as seen by a flag cell
    typedef struct packed {
        logic is_edge;   // source latches edges
        logic hit;       // qualifying edge this cycle
        logic active;    // level is asserted (level sources)
    } det_ev_t;

    function automatic det_ev_t ext_detect(det_mode_e m, logic prev, logic cur);
        det_ev_t ev;
        ev.is_edge = (m != MODE_LOW);
        ev.active  = (m == MODE_LOW) && !cur;
        unique case (m)
            MODE_FALL: ev.hit = prev && !cur;
            MODE_RISE: ev.hit = !prev && cur;
            MODE_BOTH: ev.hit = prev ^ cur;
            default:   ev.hit = 1'b0;
        endcase
        return ev;
    endfunction

    function automatic det_ev_t per_detect(logic edge_kind, logic prev, logic cur);
        det_ev_t ev;
        ev.is_edge = edge_kind;
        ev.hit     = edge_kind && cur && !prev;
        ev.active  = !edge_kind && cur;
        return ev;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W       = 6,
    parameter bit RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] s1, s2, s3;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                s1[i] <= RST_VAL;
                s2[i] <= RST_VAL;
                s3[i] <= RST_VAL;
            end else begin
                s1[i] <= d[i];
                s2[i] <= s1[i];
                s3[i] <= s2[i];
            end
        end
    end

    assign q      = s2;
    assign q_prev = s3;
endmodule

// File: rtl/irq_flag.sv
module irq_flag
    import irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  det_ev_t ev,
    input  logic    clr,
    output logic    flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (ev.is_edge)
            flag <= ev.hit | (flag & ~clr);
        else
            flag <= ev.active;
    end

    // R10
    edge_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.is_edge && ev.hit) |=> flag);

    // R4
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ev.is_edge && ev.active) |=> flag);

    // R7
    edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.is_edge && clr && !ev.hit) |=> !flag);
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int N   = 10,
    parameter int PW  = 4,
    parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    cand,
    input  logic [N*PW-1:0] prio,
    output logic            req,
    output logic [IDW-1:0]  id,
    output logic [PW-1:0]   lvl
);
    always_comb begin
        lvl = '0;
        id  = '0;
        // strict compare keeps the lower index on ties; 0 never wins
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (prio[i*PW +: PW] > lvl)) begin
                lvl = prio[i*PW +: PW];
                id  = IDW'(i);
            end
        end
        req = (lvl != '0);
    end
endmodule

// File: rtl/irq_detect_unit.sv
module irq_detect_unit
    import irq_pkg::*;
#(
    parameter int              N_EXT    = 6,
    parameter int              N_PER    = 4,
    parameter int              PW       = 4,
    parameter logic [N_PER-1:0] PER_EDGE = 4'b0011,
    parameter int              N_SRC    = N_EXT + N_PER,
    parameter int              IDW      = $clog2(N_SRC)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_EXT-1:0]    ext_pin,
    input  logic [2*N_EXT-1:0]  ext_mode,
    input  logic [N_PER-1:0]    per_line,
    input  logic [N_SRC-1:0]    src_en,
    input  logic [N_SRC-1:0]    src_to_xfer,
    input  logic [PW*N_SRC-1:0] src_prio,
    input  logic                cpu_ack,
    input  logic [IDW-1:0]      cpu_ack_id,
    input  logic [N_SRC-1:0]    xfer_ack,
    output logic [N_SRC-1:0]    flags,
    output logic                cpu_req,
    output logic [IDW-1:0]      cpu_req_id,
    output logic [PW-1:0]       cpu_req_prio,
    output logic [N_SRC-1:0]    xfer_req
);
    logic [N_EXT-1:0] ext_cur, ext_prev;
    logic [N_PER-1:0] per_prev;
    det_ev_t          ev  [N_SRC];
    logic [N_SRC-1:0] clr;
    logic [N_SRC-1:0] cpu_cand;

    irq_sync #(.W(N_EXT), .RST_VAL(1'b1)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d      (ext_pin),
        .q      (ext_cur),
        .q_prev (ext_prev)
    );

    always_ff @(posedge clk) begin
        if (rst) per_prev <= '0;
        else     per_prev <= per_line;
    end

    for (genvar i = 0; i < N_EXT; i++) begin : g_ext
        assign ev[i] = ext_detect(det_mode_e'(ext_mode[2*i +: 2]),
                                  ext_prev[i], ext_cur[i]);
    end

    for (genvar j = 0; j < N_PER; j++) begin : g_per
        assign ev[N_EXT+j] = per_detect(PER_EDGE[j], per_prev[j], per_line[j]);
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign clr[i] = src_to_xfer[i] ? xfer_ack[i]
                                       : (cpu_ack && (cpu_ack_id == IDW'(i)));
        irq_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .ev   (ev[i]),
            .clr  (clr[i]),
            .flag (flags[i])
        );
        assign cpu_cand[i] = flags[i] && src_en[i] && !src_to_xfer[i];
        assign xfer_req[i] = flags[i] && src_en[i] &&  src_to_xfer[i];
    end

    irq_prio #(.N(N_SRC), .PW(PW), .IDW(IDW)) u_prio (
        .cand (cpu_cand),
        .prio (src_prio),
        .req  (cpu_req),
        .id   (cpu_req_id),
        .lvl  (cpu_req_prio)
    );

    // R5
    win_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_req |-> (src_en[cpu_req_id] && flags[cpu_req_id]));

    // R6
    win_route_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_req |-> (!src_to_xfer[cpu_req_id] && !xfer_req[cpu_req_id]));

    // R9
    win_prio_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_req |-> (cpu_req_prio != '0 &&
                     cpu_req_prio == src_prio[cpu_req_id*PW +: PW]));

    // R11
    reset_clean_chk: assert property (@(posedge clk)
        $past(rst) |-> (flags == '0 && !cpu_req && xfer_req == '0));
endmodule

// File: tb/sim_irq_detect_unit.sv
module sim_irq_detect_unit;
    localparam int N_EXT = 6;
    localparam int N_PER = 4;
    localparam int N_SRC = 10;
    localparam int IDW   = 4;

    logic                clk = 1'b0;
    logic                rst;
    logic [N_EXT-1:0]    ext_pin;
    logic [2*N_EXT-1:0]  ext_mode;
    logic [N_PER-1:0]    per_line;
    logic [N_SRC-1:0]    src_en, src_to_xfer, xfer_ack;
    logic [4*N_SRC-1:0]  src_prio;
    logic                cpu_ack;
    logic [IDW-1:0]      cpu_ack_id;
    logic [N_SRC-1:0]    flags, xfer_req;
    logic                cpu_req;
    logic [IDW-1:0]      cpu_req_id;
    logic [3:0]          cpu_req_prio;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq_detect_unit u0 (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .ext_mode(ext_mode),
        .per_line(per_line), .src_en(src_en), .src_to_xfer(src_to_xfer),
        .src_prio(src_prio), .cpu_ack(cpu_ack), .cpu_ack_id(cpu_ack_id),
        .xfer_ack(xfer_ack), .flags(flags), .cpu_req(cpu_req),
        .cpu_req_id(cpu_req_id), .cpu_req_prio(cpu_req_prio),
        .xfer_req(xfer_req)
    );

    // level-low priority vectors: pins, external priorities, expected result
    typedef struct packed {
        logic [5:0]  pins;
        logic [23:0] prio;
        logic        exp_req;
        logic [3:0]  exp_id;
        logic [3:0]  exp_prio;
    } vec_t;

    localparam vec_t TBL [7] = '{
        '{6'b111110, 24'h111111, 1'b1, 4'd0, 4'd1},
        '{6'b111100, 24'h000053, 1'b1, 4'd1, 4'd5},
        '{6'b000000, 24'h777777, 1'b1, 4'd0, 4'd7},
        '{6'b110011, 24'h004400, 1'b1, 4'd2, 4'd4},
        '{6'b011111, 24'h000000, 1'b0, 4'd0, 4'd0},
        '{6'b000000, 24'h1F1120, 1'b1, 4'd4, 4'd15},
        '{6'b111111, 24'h111111, 1'b0, 4'd0, 4'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_cpu(input int id);
        cpu_ack    = 1'b1;
        cpu_ack_id = IDW'(id);
        ticks(1);
        cpu_ack    = 1'b0;
    endtask

    task automatic ack_xfer(input int id);
        xfer_ack[id] = 1'b1;
        ticks(1);
        xfer_ack = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ext_pin = '1; ext_mode = '0; per_line = '0;
        src_en = '1; src_to_xfer = '0; xfer_ack = '0;
        src_prio = '0; cpu_ack = 1'b0; cpu_ack_id = '0;
        ticks(3);
        rst = 1'b0;
        // R11 reset state
        check("R11 flags", 32'(flags), 0);
        check("R11 cpu_req", 32'(cpu_req), 0);
        check("R11 xfer_req", 32'(xfer_req), 0);

        // R9 priority table (external pins in level-low mode)
        foreach (TBL[k]) begin
            ext_pin = TBL[k].pins;
            src_prio[23:0] = TBL[k].prio;
            ticks(4);
            check("R9 req", 32'(cpu_req), 32'(TBL[k].exp_req));
            if (TBL[k].exp_req) begin
                check("R9 id", 32'(cpu_req_id), 32'(TBL[k].exp_id));
                check("R9 prio", 32'(cpu_req_prio), 32'(TBL[k].exp_prio));
            end
        end
        ext_pin = '1;
        src_prio = '0;
        ticks(4);

        // R1 rising mode ignores a falling pin
        ext_mode[1:0] = 2'b10;
        ext_pin[0] = 1'b0;
        ticks(4);
        check("R1 rise ignores fall", 32'(flags[0]), 0);
        // R2 latency of three clock edges
        ext_pin[0] = 1'b1;
        ticks(2);
        check("R2 not after two edges", 32'(flags[0]), 0);
        ticks(1);
        check("R2 set after three edges", 32'(flags[0]), 1);
        src_prio[3:0] = 4'd9;
        ticks(1);
        check("R9 single winner id", 32'(cpu_req_id), 0);
        check("R9 single winner prio", 32'(cpu_req_prio), 9);
        ack_cpu(0);
        check("R7 cpu ack clears", 32'(flags[0]), 0);
        check("R7 request gone", 32'(cpu_req), 0);

        // R1 falling mode on source 1
        ext_mode[3:2] = 2'b01;
        ext_pin[1] = 1'b0;
        ticks(3);
        check("R1 falling sets", 32'(flags[1]), 1);
        ack_cpu(1);
        check("R7 clear src1", 32'(flags[1]), 0);
        // R1 both edges on source 2
        ext_mode[5:4] = 2'b11;
        ext_pin[2] = 1'b0;
        ticks(3);
        check("R1 both: fall", 32'(flags[2]), 1);
        ack_cpu(2);
        ext_pin[2] = 1'b1;
        ticks(3);
        check("R1 both: rise", 32'(flags[2]), 1);
        ack_cpu(2);
        check("R7 clear src2", 32'(flags[2]), 0);

        // R4 level-low on source 3 survives an ack
        ext_pin[3] = 1'b0;
        ticks(3);
        check("R4 level sets", 32'(flags[3]), 1);
        ack_cpu(3);
        check("R4 ack ignored while active", 32'(flags[3]), 1);
        ext_pin[3] = 1'b1;
        ticks(3);
        check("R4 drops when inactive", 32'(flags[3]), 0);

        // R3 peripheral edge line (source 6)
        per_line[0] = 1'b1;
        ticks(1);
        check("R3 edge periph sets next edge", 32'(flags[6]), 1);
        ticks(2);
        check("R3 edge periph holds", 32'(flags[6]), 1);
        // R3 peripheral level line (source 8)
        per_line[2] = 1'b1;
        ticks(1);
        check("R3 level periph sets", 32'(flags[8]), 1);
        per_line[2] = 1'b0;
        ticks(1);
        check("R3 level periph follows", 32'(flags[8]), 0);

        // R6 routing of source 6
        src_prio[27:24] = 4'd5;
        ticks(1);
        check("R6 cpu route id", 32'(cpu_req_id), 6);
        check("R6 cpu route no xfer", 32'(xfer_req), 0);
        src_to_xfer[6] = 1'b1;
        ticks(1);
        check("R6 xfer route req", 32'(xfer_req), 32'h40);
        check("R6 xfer route no cpu", 32'(cpu_req), 0);
        // R5 enable gates request, flag kept
        src_en[6] = 1'b0;
        ticks(1);
        check("R5 disabled no req", 32'(xfer_req), 0);
        check("R5 flag kept", 32'(flags[6]), 1);
        src_en[6] = 1'b1;
        // R7 cpu ack ignored for transfer route
        ack_cpu(6);
        check("R7 cpu ack ignored on xfer source", 32'(flags[6]), 1);
        // R8 transfer ack clears
        ack_xfer(6);
        check("R8 xfer ack clears", 32'(flags[6]), 0);

        // R8 transfer ack ignored on cpu-routed source 7
        per_line[1] = 1'b1;
        ticks(1);
        check("R3 src7 sets", 32'(flags[7]), 1);
        ack_xfer(7);
        check("R8 xfer ack ignored on cpu source", 32'(flags[7]), 1);
        // R10 new edge with its acknowledge
        per_line[1] = 1'b0;
        ticks(1);
        per_line[1] = 1'b1;
        cpu_ack = 1'b1;
        cpu_ack_id = 4'd7;
        ticks(1);
        cpu_ack = 1'b0;
        check("R10 edge with ack keeps flag", 32'(flags[7]), 1);
        ack_cpu(7);
        check("R7 clear src7", 32'(flags[7]), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule